// File: doc/BRIEF.md
# Gated Down-Counter Channel with Snapshot Readback

This block is a single 16-bit timer channel. It keeps three separate stages: a hold register for the count the host writes, a working register that counts down, and a readback stage. The readback stage either follows the working register or keeps a frozen snapshot of it. The channel clock and the gate arrive without any timing relation to the system clock. Both are brought into the system clock domain, and each falling edge of the synchronized channel clock is one counting event.

The host writes a start value N. N waits in the hold register until the next falling edge of the channel clock, which moves it into the working register. After that, each falling edge lowers the count by one, in binary or in four-digit BCD, as long as the gate is high. The output goes low when a value is written and goes high when the count reaches zero. The host reads the count one byte at a time, low byte first. It can issue a snapshot command so that both bytes come from the same instant while counting goes on.

Top module: `dct_channel`

## Requirements
- R1: After synchronous reset the working register is zero, `out_o` is 1, and the readback stage follows the live count with its byte pointer on the low byte, so `rd_data_o` is 0x00.
- R2: A cycle with `ld_en_i`=1 stores `ld_val_i` in the hold register and drives `out_o` low from the next system cycle. The working register keeps its value until the next falling channel-clock edge.
- R3: The first falling channel-clock edge after a write copies the hold register into the working register, whatever the gate level. That edge does not also decrement.
- R4: Each later falling edge of the synchronized `tclk_i` lowers the count by one when the gate is high. Rising edges of `tclk_i` never change the count.
- R5: While `gate_i` is 0, falling channel-clock edges leave the count unchanged.
- R6: With `bcd_mode_i`=0 the count is plain binary and wraps from 0x0000 to 0xFFFF.
- R7: With `bcd_mode_i`=1 the count is four BCD digits (bits 3:0 are the least significant digit). It decrements with a borrow between digits and wraps from 0x0000 to 0x9999.
- R8: `out_o` goes high on the decrement that makes the count zero. It stays high, even if the count wraps, until the next write.
- R9: `rd_data_o` presents bits 7:0 first. A pulse on `rd_en_i` moves the pointer to bits 15:8, and a second pulse returns it to bits 7:0. With no snapshot held, the bytes come from the live count.
- R10: A `latch_i` pulse with no snapshot held captures the live count and starts the byte sequence again at the low byte. Counting continues, and both bytes return the captured value.
- R11: A snapshot is released only by the `rd_en_i` pulse that consumes its high byte. Until then even a changed live count is not shown.
- R12: A `latch_i` pulse while a snapshot is still held is ignored, and the held value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_i | input | 1 | Asynchronous channel clock; falling edges are counting events |
| gate_i | input | 1 | Asynchronous count enable, high to count |
| bcd_mode_i | input | 1 | 1 selects BCD counting, 0 selects binary |
| ld_en_i | input | 1 | One-cycle strobe writing a new start value |
| ld_val_i | input | 16 | Start value written by `ld_en_i` |
| latch_i | input | 1 | One-cycle snapshot command |
| rd_en_i | input | 1 | One-cycle strobe consuming the presented byte |
| rd_data_o | output | 8 | Byte currently presented to the host |
| out_o | output | 1 | Terminal-count output |

## Verification
A falling `tclk_i` takes two synchronizer cycles and then one register cycle to reach the working register. The count therefore changes in the third system cycle after the edge, and `out_o` rises in that same cycle. Writes, snapshot commands and byte reads all take effect one system cycle after their strobe. The bench holds every `tclk_i` level for four system cycles, drives inputs on the falling system clock edge, and samples on the falling edge that follows. Every sample falls after the due cycle and before the next event. Each vector writes a value, runs a set number of channel-clock pulses, takes a snapshot and reads both bytes. Directed sequences then cover the hold-versus-working split, rising-edge immunity and the snapshot protocol.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Width of the working register and of the start value
    localparam int CNT_W    = 16;
    // Readback is delivered one byte at a time
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = CNT_W / BYTE_W;
    localparam int RB_IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int DIGITS   = CNT_W / 4;

    typedef enum logic {
        BASE_BIN = 1'b0,
        BASE_BCD = 1'b1
    } cnt_base_e;

    // Readback stage state: snapshot flag, byte pointer, captured value
    typedef struct packed {
        logic                held;
        logic [RB_IDX_W-1:0] idx;
        logic [CNT_W-1:0]    snap;
    } rb_state_t;

    // Decrement by one across packed decimal digits; zero wraps to all nines
    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (v[d*4 +: 4] == 4'd0) begin
                    r[d*4 +: 4] = 4'd9;
                end else begin
                    r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tclk_a,
    input  logic gate_a,
    output logic tick_o,
    output logic gate_o
);

    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] gate_sh;
    logic              clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh   <= '0;
            gate_sh  <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[STAGES-2:0], tclk_a};
            gate_sh  <= {gate_sh[STAGES-2:0], gate_a};
            clk_prev <= clk_sh[STAGES-1];
        end
    end

    // Both paths have the same depth, so the gate is sampled with its edge
    assign tick_o = clk_prev & ~clk_sh[STAGES-1];
    assign gate_o = gate_sh[STAGES-1];

endmodule

// File: rtl/dct_count_core.sv
module dct_count_core
    import dct_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         gate_s,
    input  cnt_base_e    base,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_o,
    output logic         out_o
);

    logic [W-1:0] hold_q;
    logic [W-1:0] cnt_q;
    logic         pend_q;
    logic         out_q;
    logic [W-1:0] next_val;

    always_comb begin
        if (base == BASE_BCD) next_val = bcd_dec(cnt_q);
        else                  next_val = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            out_q  <= 1'b1;
        end else begin
            if (ld_en) begin
                hold_q <= ld_val;
                pend_q <= 1'b1;
                out_q  <= 1'b0;
            end
            if (tick) begin
                if (pend_q) begin
                    cnt_q <= hold_q;
                    if (!ld_en) pend_q <= 1'b0;
                end else if (gate_s) begin
                    cnt_q <= next_val;
                    if ((next_val == '0) && !ld_en) out_q <= 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign out_o = out_q;

endmodule

// File: rtl/dct_readback.sv
module dct_readback
    import dct_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        live,
    input  logic                latch_cmd,
    input  logic                rd_en,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                held_o,
    output logic [RB_IDX_W-1:0] idx_o,
    output logic [W-1:0]        snap_o
);

    localparam int NB = W / BYTE_W;

    rb_state_t          st_q, st_d;
    logic [W-1:0]       view;
    logic [BYTE_W-1:0]  byte_sel [NB];
    logic               last;

    assign view = st_q.held ? st_q.snap : live;

    for (genvar b = 0; b < NB; b++) begin : g_bytes
        assign byte_sel[b] = view[b*BYTE_W +: BYTE_W];
    end

    assign rd_data = byte_sel[st_q.idx];
    assign last    = (st_q.idx == RB_IDX_W'(NB-1));

    always_comb begin
        st_d = st_q;
        if (latch_cmd && !st_q.held) begin
            st_d.held = 1'b1;
            st_d.snap = live;
            st_d.idx  = '0;
        end else if (rd_en) begin
            if (last) begin
                st_d.idx  = '0;
                st_d.held = 1'b0;
            end else begin
                st_d.idx = st_q.idx + RB_IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held_o = st_q.held;
    assign idx_o  = st_q.idx;
    assign snap_o = st_q.snap;

endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk_i,
    input  logic              gate_i,
    input  logic              bcd_mode_i,
    input  logic              ld_en_i,
    input  logic [CNT_W-1:0]  ld_val_i,
    input  logic              latch_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              out_o
);

    logic                tick;
    logic                gate_s;
    cnt_base_e           base;
    logic [CNT_W-1:0]    cnt;
    logic                rb_held;
    logic [RB_IDX_W-1:0] rb_idx;
    logic [CNT_W-1:0]    rb_snap;

    assign base = bcd_mode_i ? BASE_BCD : BASE_BIN;

    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .tclk_a (tclk_i),
        .gate_a (gate_i),
        .tick_o (tick),
        .gate_o (gate_s)
    );

    dct_count_core #(.W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .gate_s (gate_s),
        .base   (base),
        .ld_en  (ld_en_i),
        .ld_val (ld_val_i),
        .cnt_o  (cnt),
        .out_o  (out_o)
    );

    dct_readback #(.W(CNT_W)) u_rb (
        .clk       (clk),
        .rst       (rst),
        .live      (cnt),
        .latch_cmd (latch_i),
        .rd_en     (rd_en_i),
        .rd_data   (rd_data_o),
        .held_o    (rb_held),
        .idx_o     (rb_idx),
        .snap_o    (rb_snap)
    );

endmodule

// File: rtl/dct_channel_chk.sv
module dct_channel_chk #(
    parameter int W     = 16,
    parameter int IDX_W = 1,
    parameter int NB    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_en,
    input logic             rd_en,
    input logic             out,
    input logic             tick,
    input logic [W-1:0]     cnt,
    input logic             held,
    input logic [IDX_W-1:0] idx,
    input logic [W-1:0]     snap
);

    logic last;
    assign last = (idx == IDX_W'(NB-1));

    // R2
    ld_lowers_out_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> !out);

    // R2
    out_fall_needs_ld_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out) |-> $past(ld_en));

    // R8
    out_rise_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out) |-> (cnt == '0));

    // R4
    count_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R10 R12
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !(rd_en && last)) |=> (held && $stable(snap)));

    // R11
    snap_release_chk: assert property (@(posedge clk) disable iff (rst)
        (held && rd_en && last) |=> !held);

endmodule

bind dct_channel dct_channel_chk #(
    .W     (dct_pkg::CNT_W),
    .IDX_W (dct_pkg::RB_IDX_W),
    .NB    (dct_pkg::NBYTES)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ld_en (ld_en_i),
    .rd_en (rd_en_i),
    .out   (out_o),
    .tick  (tick),
    .cnt   (cnt),
    .held  (rb_held),
    .idx   (rb_idx),
    .snap  (rb_snap)
);

// File: tb/dct_channel_test.sv
`timescale 1ns/1ps
module dct_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tclk_i = 1'b1;
    logic        gate_i = 1'b0;
    logic        bcd_mode_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [15:0] ld_val_i = '0;
    logic        latch_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        out_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dct_channel uut (
        .clk        (clk),
        .rst        (rst),
        .tclk_i     (tclk_i),
        .gate_i     (gate_i),
        .bcd_mode_i (bcd_mode_i),
        .ld_en_i    (ld_en_i),
        .ld_val_i   (ld_val_i),
        .latch_i    (latch_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .out_o      (out_o)
    );

    typedef struct packed {
        logic        bcd;
        logic [15:0] n;
        logic [3:0]  pulses;
        logic        gate;
        logic [15:0] expv;
        logic        expo;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd5,     4'd3, 1'b1, 16'd2,     1'b0},
        '{1'b0, 16'd5,     4'd5, 1'b1, 16'd0,     1'b1},
        '{1'b0, 16'h0100,  4'd1, 1'b1, 16'h00FF,  1'b0},
        '{1'b0, 16'h0001,  4'd2, 1'b1, 16'hFFFF,  1'b1},
        '{1'b1, 16'h0100,  4'd1, 1'b1, 16'h0099,  1'b0},
        '{1'b1, 16'h1000,  4'd1, 1'b1, 16'h0999,  1'b0},
        '{1'b1, 16'h0001,  4'd2, 1'b1, 16'h9999,  1'b1},
        '{1'b0, 16'd7,     4'd3, 1'b0, 16'd7,     1'b0},
        '{1'b1, 16'h0010,  4'd3, 1'b1, 16'h0007,  1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chan_pulse();
        tclk_i = 1'b0;
        repeat (4) @(negedge clk);
        tclk_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] v);
        @(negedge clk);
        ld_en_i  = 1'b1;
        ld_val_i = v;
        @(negedge clk);
        ld_en_i  = 1'b0;
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_i = 1'b1;
        @(negedge clk);
        latch_i = 1'b0;
    endtask

    task automatic read_word(output logic [15:0] w);
        logic [7:0] lo;
        logic [7:0] hi;
        @(negedge clk);
        lo = rd_data_o;
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        hi = rd_data_o;
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        w = {hi, lo};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        string tag;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {15'd0, out_o}, 16'd1);
        chk("R1", {8'd0, rd_data_o}, 16'd0);
        read_word(w);
        chk("R1", w, 16'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bcd_mode_i = VECS[i].bcd;
            gate_i = 1'b1;
            do_load(VECS[i].n);
            chk("R2", {15'd0, out_o}, 16'd0);
            chan_pulse();
            gate_i = VECS[i].gate;
            repeat (2) @(negedge clk);
            for (int p = 0; p < int'(VECS[i].pulses); p++) chan_pulse();
            do_latch();
            read_word(w);
            tag = !VECS[i].gate ? "R5" : (VECS[i].bcd ? "R7" : "R6");
            chk(tag, w, VECS[i].expv);
            chk("R8", {15'd0, out_o}, {15'd0, VECS[i].expo});
        end

        // R2 R3 R4: hold vs working register, rising-edge immunity
        bcd_mode_i = 1'b0;
        gate_i = 1'b1;
        do_load(16'd9);
        chan_pulse();
        chan_pulse();
        chan_pulse();
        do_load(16'd20);
        chk("R2", {15'd0, out_o}, 16'd0);
        repeat (6) @(negedge clk);
        read_word(w);
        chk("R2", w, 16'd7);
        tclk_i = 1'b0;
        repeat (5) @(negedge clk);
        read_word(w);
        chk("R3", w, 16'd20);
        tclk_i = 1'b1;
        repeat (5) @(negedge clk);
        read_word(w);
        chk("R4", w, 16'd20);
        chan_pulse();
        read_word(w);
        chk("R4", w, 16'd19);

        // R10 R11: snapshot frozen while counting continues
        do_load(16'd50);
        chan_pulse();
        do_latch();
        chan_pulse();
        chan_pulse();
        chan_pulse();
        read_word(w);
        chk("R10", w, 16'd50);
        read_word(w);
        chk("R11", w, 16'd47);

        // R12: second snapshot command ignored
        do_load(16'd100);
        chan_pulse();
        do_latch();
        chan_pulse();
        chan_pulse();
        do_latch();
        chan_pulse();
        read_word(w);
        chk("R12", w, 16'd100);
        read_word(w);
        chk("R9", w, 16'd97);

        // R11: release only after high byte, live high byte changes meanwhile
        do_load(16'h0100);
        chan_pulse();
        do_latch();
        @(negedge clk);
        chk("R9", {8'd0, rd_data_o}, 16'h0000);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chan_pulse();
        chk("R11", {8'd0, rd_data_o}, 16'h0001);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk("R9", {8'd0, rd_data_o}, 16'h00FF);
        read_word(w);
        chk("R11", w, 16'h00FF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule